// File: doc/BRIEF.md
# Completion Payload Segmenter

This block cuts the data of one read completion into packets for a serial link. A request gives a starting byte address and a byte length. The data then arrives as 8-byte beats. The block sends one header descriptor for each packet, followed by that packet's beats. A packet ends wherever the data reaches an address boundary that is aligned to the selected maximum payload size. A packet also ends when the request runs out of data.

The maximum payload size comes from a 2-bit size field. An override input limits every packet to 128 bytes. Both configuration inputs are captured when a request is accepted and hold for that whole request. The captured copies reset to size code 0 and override 0.

The controller is a three-state machine:
- `S_IDLE` waits for a request and takes it (transition ACCEPT).
- `S_HDR` presents the descriptor of the packet that is due; on the header handshake it moves to `S_DATA` (transition HDR_SENT).
- `S_DATA` forwards beats. On the last beat of a packet it goes back to `S_HDR` if bytes remain (transition PKT_CLOSE), or to `S_IDLE` if the request is finished (transition REQ_DONE).

Top module: `cps_segmenter`

## Requirements
- R1: After reset, `req_ready` is 1 and both `hdr_valid` and `out_valid` are 0.
- R2: The size field code 0 selects a 128-byte maximum, code 1 selects 256 bytes and code 2 selects 512 bytes. Code 3 is treated as 128 bytes.
- R3: While the captured override is 1, no packet exceeds 128 bytes, whatever the size field holds.
- R4: A packet never crosses a boundary aligned to the maximum size. The first packet runs from the start address up to the next such boundary, so it can be shorter than the maximum.
- R5: When the request ends before a boundary, the last packet carries the remaining bytes.
- R6: Each descriptor carries three fields:
  - `hdr_byte_cnt`: the packet's byte count, which is nonzero.
  - `hdr_lower_addr`: bits [6:0] of the packet's first byte address.
  - `hdr_remain`: the bytes still owed to the request, this packet included.
- R7: A packet's descriptor is sent before its beats. Beats leave in arrival order with their data unchanged. `out_last` is 1 on exactly the final beat of each packet.
- R8: The size field and the override are sampled when the request is accepted. Changes to them while the request is in progress have no effect on that request.
- R9: While `hdr_valid` is 1 and `hdr_ready` is 0, the descriptor fields hold their values. While `out_valid` is 1 and `out_ready` is 0, the beat holds its data.
- R10: Start addresses and lengths are multiples of 8, and lengths run from 8 to 4096 bytes. A request of the full 4096 bytes is segmented correctly. `req_ready` stays 0 until the final beat of the current request has been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mps_field | input | 2 | Maximum payload size code |
| force_128 | input | 1 | Override that limits packets to 128 bytes |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted (controller idle) |
| req_addr | input | ADDR_W (16) | Start byte address, a multiple of 8 |
| req_len | input | LEN_W (13) | Request length in bytes |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat taken |
| in_data | input | DATA_W (64) | Input beat data |
| hdr_valid | output | 1 | Descriptor valid |
| hdr_ready | input | 1 | Descriptor taken by the queue |
| hdr_byte_cnt | output | LEN_W (13) | Packet byte count |
| hdr_lower_addr | output | LOW_ADDR_W (7) | Low bits of the packet's first byte address |
| hdr_remain | output | LEN_W (13) | Bytes left in the request, this packet included |
| out_valid | output | 1 | Payload beat valid |
| out_ready | input | 1 | Payload beat taken by the queue |
| out_data | output | DATA_W (64) | Payload beat data |
| out_last | output | 1 | Final beat of the packet |

## Verification
The hardest case to reach from the ports is a configuration change that lands after a request has been accepted but before its final packet. If the design wrongly re-read the inputs, the boundaries of the later packets would move. The driver changes the size field and the override on the cycle right after the request handshake. The scoreboard keeps expecting packets split by the values captured at acceptance.

Two further cases are reached with chosen start addresses. A start address 8 bytes below a 512-byte boundary produces an 8-byte first packet. The full 4096-byte request ends with an 8-byte last packet. Alternating ready patterns hold descriptors and beats under backpressure so that the hold checks are exercised.

// File: rtl/cps_pkg.sv
package cps_pkg;

    // Controller states of the segmenter
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HDR  = 2'd1,
        S_DATA = 2'd2
    } seg_state_e;

    // Smallest packet limit; larger limits are this value shifted left
    localparam int unsigned BASE_PKT_BYTES = 128;

endpackage

// File: rtl/cps_cfg_latch.sv
module cps_cfg_latch #(
    parameter int FIELD_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture_i,
    input  logic [FIELD_W-1:0] field_i,
    input  logic               force_i,
    output logic [FIELD_W-1:0] field_o,
    output logic               force_o
);

    // Configuration is frozen for the life of one request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            field_o <= '0;
            force_o <= 1'b0;
        end else if (capture_i) begin
            field_o <= field_i;
            force_o <= force_i;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> $stable(field_o) && $stable(force_o)); // R8

endmodule

// File: rtl/cps_size_sel.sv
module cps_size_sel #(
    parameter int LEN_W     = 13,
    parameter int FIELD_W   = 2,
    parameter int NUM_SIZES = 3
) (
    input  logic [FIELD_W-1:0] field_i,
    input  logic               force_i,
    output logic [LEN_W-1:0]   max_bytes_o
);
    import cps_pkg::*;

    localparam logic [LEN_W-1:0] BASE_LEN = LEN_W'(BASE_PKT_BYTES);

    logic [LEN_W-1:0] size_tab [NUM_SIZES];

    // One entry per legal size code
    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        assign size_tab[g] = BASE_LEN << g;
    end

    always_comb begin
        max_bytes_o = BASE_LEN;
        if (!force_i) begin
            for (int k = 0; k < NUM_SIZES; k++) begin
                if (int'(field_i) == k) max_bytes_o = size_tab[k];
            end
        end
    end

endmodule

// File: rtl/cps_pkt_calc.sv
module cps_pkt_calc #(
    parameter int LEN_W = 13
) (
    input  logic [LEN_W-1:0] addr_low_i,
    input  logic [LEN_W-1:0] remain_i,
    input  logic [LEN_W-1:0] max_bytes_i,
    output logic [LEN_W-1:0] pkt_bytes_o
);

    logic [LEN_W-1:0] offset;
    logic [LEN_W-1:0] to_bound;

    // Distance to the next aligned boundary, clipped to what is left
    always_comb begin
        offset      = addr_low_i & (max_bytes_i - LEN_W'(1));
        to_bound    = max_bytes_i - offset;
        pkt_bytes_o = (remain_i < to_bound) ? remain_i : to_bound;
    end

endmodule

// File: rtl/cps_segmenter.sv
module cps_segmenter #(
    parameter  int ADDR_W        = 16,
    parameter  int BEAT_BYTES    = 8,
    parameter  int MAX_REQ_BYTES = 4096,
    parameter  int LOW_ADDR_W    = 7,
    parameter  int FIELD_W       = 2,
    parameter  int NUM_SIZES     = 3,
    localparam int DATA_W        = BEAT_BYTES * 8,
    localparam int LEN_W         = $clog2(MAX_REQ_BYTES) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [FIELD_W-1:0]    mps_field,
    input  logic                  force_128,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [LEN_W-1:0]      req_len,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [DATA_W-1:0]     in_data,
    output logic                  hdr_valid,
    input  logic                  hdr_ready,
    output logic [LEN_W-1:0]      hdr_byte_cnt,
    output logic [LOW_ADDR_W-1:0] hdr_lower_addr,
    output logic [LEN_W-1:0]      hdr_remain,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [DATA_W-1:0]     out_data,
    output logic                  out_last
);
    import cps_pkg::*;

    localparam logic [LEN_W-1:0]  BEAT_LEN  = LEN_W'(BEAT_BYTES);
    localparam logic [ADDR_W-1:0] BEAT_ADDR = ADDR_W'(BEAT_BYTES);

    seg_state_e state_q, state_d;

    logic [ADDR_W-1:0]  addr_q;
    logic [LEN_W-1:0]   remain_q;
    logic [LEN_W-1:0]   pkt_left_q;
    logic [FIELD_W-1:0] cfg_field_q;
    logic               cfg_force_q;
    logic [LEN_W-1:0]   max_bytes;
    logic [LEN_W-1:0]   pkt_bytes;

    logic accept, hdr_fire, beat_fire, beat_last, req_done;

    assign accept    = (state_q == S_IDLE) && req_valid;
    assign hdr_fire  = (state_q == S_HDR) && hdr_ready;
    assign beat_fire = (state_q == S_DATA) && in_valid && out_ready;
    assign beat_last = (pkt_left_q == BEAT_LEN);
    assign req_done  = beat_fire && beat_last && (remain_q == BEAT_LEN);

    cps_cfg_latch #(.FIELD_W(FIELD_W)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (accept),
        .field_i   (mps_field),
        .force_i   (force_128),
        .field_o   (cfg_field_q),
        .force_o   (cfg_force_q)
    );

    cps_size_sel #(.LEN_W(LEN_W), .FIELD_W(FIELD_W), .NUM_SIZES(NUM_SIZES)) size_i (
        .field_i     (cfg_field_q),
        .force_i     (cfg_force_q),
        .max_bytes_o (max_bytes)
    );

    cps_pkt_calc #(.LEN_W(LEN_W)) calc_i (
        .addr_low_i  (addr_q[LEN_W-1:0]),
        .remain_i    (remain_q),
        .max_bytes_i (max_bytes),
        .pkt_bytes_o (pkt_bytes)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: ACCEPT, HDR_SENT, PKT_CLOSE, REQ_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept)   state_d = S_HDR;
            S_HDR:  if (hdr_fire) state_d = S_DATA;
            S_DATA: begin
                if (req_done)                    state_d = S_IDLE;
                else if (beat_fire && beat_last) state_d = S_HDR;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Request position tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            remain_q   <= '0;
            pkt_left_q <= '0;
        end else begin
            if (accept) begin
                addr_q   <= req_addr;
                remain_q <= req_len;
            end
            if (hdr_fire) pkt_left_q <= pkt_bytes;
            if (beat_fire) begin
                addr_q     <= addr_q + BEAT_ADDR;
                remain_q   <= remain_q - BEAT_LEN;
                pkt_left_q <= pkt_left_q - BEAT_LEN;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready      = 1'b0;
        hdr_valid      = 1'b0;
        in_ready       = 1'b0;
        out_valid      = 1'b0;
        out_last       = 1'b0;
        hdr_byte_cnt   = pkt_bytes;
        hdr_lower_addr = addr_q[LOW_ADDR_W-1:0];
        hdr_remain     = remain_q;
        out_data       = in_data;
        unique case (state_q)
            S_IDLE: req_ready = 1'b1;
            S_HDR:  hdr_valid = 1'b1;
            S_DATA: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_last  = beat_last;
            end
            default: ;
        endcase
    end

    AST_PKT_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> ((addr_q ^ (addr_q + ADDR_W'(hdr_byte_cnt) - ADDR_W'(1)))
                       & ~ADDR_W'(max_bytes - LEN_W'(1))) == '0); // R4

    AST_PKT_SANE: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> (hdr_byte_cnt != '0) && (hdr_byte_cnt <= hdr_remain)); // R6

    AST_FORCE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && cfg_force_q |-> hdr_byte_cnt <= LEN_W'(BASE_PKT_BYTES)); // R3

    AST_HDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && !hdr_ready |=> hdr_valid && $stable(hdr_byte_cnt)
                                    && $stable(hdr_remain) && $stable(hdr_lower_addr)); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last && (hdr_remain == BEAT_LEN) |=> req_ready); // R10

    AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> !req_ready && !out_valid); // R7

endmodule

// File: tb/cps_segmenter_tb_top.sv
module cps_segmenter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int LEN_W      = 13;
    localparam int DATA_W     = 64;
    localparam int LOW_W      = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mps_field = '0;
    logic              force_128 = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DATA_W-1:0] in_data = '0;
    logic              hdr_valid;
    logic              hdr_ready = 1'b0;
    logic [LEN_W-1:0]  hdr_byte_cnt;
    logic [LOW_W-1:0]  hdr_lower_addr;
    logic [LEN_W-1:0]  hdr_remain;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [DATA_W-1:0] out_data;
    logic              out_last;

    always #(CLK_PERIOD/2) clk = ~clk;

    cps_segmenter dut_i (
        .clk(clk), .rst_n(rst_n), .mps_field(mps_field), .force_128(force_128),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_byte_cnt(hdr_byte_cnt),
        .hdr_lower_addr(hdr_lower_addr), .hdr_remain(hdr_remain),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    typedef struct { int cnt; int low; int rem; string tag; } exp_hdr_t;
    typedef struct { logic [63:0] data; bit last; string tag; } exp_beat_t;

    exp_hdr_t  exp_hdr_q[$];
    exp_beat_t exp_beat_q[$];

    int  tests = 0;
    int  fails = 0;
    int  cyc = 0;
    bit  stall_mode = 1'b0;
    bit  pkt_open = 1'b0;
    bit  done = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Driver: builds the expected packets, then offers the request and its beats
    task automatic run_req(input int addr, input int len, input int fld, input bit frc,
                           input int fld2, input bit frc2, input int id, input string tag);
        int m, a, r, n, bidx;
        exp_hdr_t  h;
        exp_beat_t bt;
        m = frc ? 128 : (fld == 0) ? 128 : (fld == 1) ? 256 : (fld == 2) ? 512 : 128;
        a = addr; r = len; bidx = 0;
        while (r > 0) begin
            n = m - (a % m);
            if (n > r) n = r;
            h.cnt = n; h.low = a % 128; h.rem = r; h.tag = tag;
            exp_hdr_q.push_back(h);
            for (int k = 0; k < n / 8; k++) begin
                bt.data = {32'(id), 32'(bidx)};
                bt.last = (k == n / 8 - 1);
                bt.tag  = tag;
                exp_beat_q.push_back(bt);
                bidx++;
            end
            a += n; r -= n;
        end
        mps_field = 2'(fld); force_128 = frc;
        req_addr = ADDR_W'(addr); req_len = LEN_W'(len); req_valid = 1'b1;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 1'b0;
        mps_field = 2'(fld2); force_128 = frc2;    // late change must be ignored (R8)
        for (int b = 0; b < len / 8; b++) begin
            if (((b + id) % 3) == 2) begin
                in_valid = 1'b0;
                @(posedge clk); #1;
            end
            in_valid = 1'b1;
            in_data  = {32'(id), 32'(b)};
            do @(negedge clk); while (!in_ready);
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
    endtask

    // Ready patterns for the completion queue side
    initial begin
        forever begin
            @(posedge clk); #1;
            cyc++;
            hdr_ready = stall_mode ? ((cyc % 4) == 0) : ((cyc % 5) != 3);
            out_ready = stall_mode ? ((cyc % 3) == 1) : ((cyc % 7) != 6);
        end
    end

    // Monitor and scoreboard
    initial begin
        bit hs_prev = 1'b0, os_prev = 1'b0;
        int p_cnt = 0, p_rem = 0, p_low = 0;
        logic [63:0] p_dat = '0;
        exp_hdr_t  h;
        exp_beat_t bt;
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                if (hs_prev)
                    check(hdr_valid && int'(hdr_byte_cnt) == p_cnt && int'(hdr_remain) == p_rem
                          && int'(hdr_lower_addr) == p_low, "R9", "header held",
                          longint'(hdr_byte_cnt), longint'(p_cnt));
                if (os_prev)
                    check(out_valid && out_data == p_dat, "R9", "beat held",
                          longint'(out_data), longint'(p_dat));
                hs_prev = hdr_valid && !hdr_ready;
                os_prev = out_valid && !out_ready;
                p_cnt = int'(hdr_byte_cnt); p_rem = int'(hdr_remain);
                p_low = int'(hdr_lower_addr); p_dat = out_data;

                if (hdr_valid && hdr_ready) begin
                    check(!pkt_open, "R7", "header before previous packet closed", 1, 0);
                    if (exp_hdr_q.size() == 0) begin
                        check(1'b0, "R5", "unexpected header", longint'(hdr_byte_cnt), 0);
                    end else begin
                        h = exp_hdr_q.pop_front();
                        check(int'(hdr_byte_cnt) == h.cnt, h.tag, "R6 byte count",
                              longint'(hdr_byte_cnt), longint'(h.cnt));
                        check(int'(hdr_lower_addr) == h.low, h.tag, "R6 lower address",
                              longint'(hdr_lower_addr), longint'(h.low));
                        check(int'(hdr_remain) == h.rem, h.tag, "R6 remaining bytes",
                              longint'(hdr_remain), longint'(h.rem));
                    end
                    pkt_open = 1'b1;
                end
                if (out_valid && out_ready) begin
                    check(pkt_open, "R7", "beat without header", 0, 1);
                    if (exp_beat_q.size() == 0) begin
                        check(1'b0, "R7", "unexpected beat", longint'(out_data), 0);
                    end else begin
                        bt = exp_beat_q.pop_front();
                        check(out_data == bt.data, bt.tag, "R7 beat data",
                              longint'(out_data), longint'(bt.data));
                        check(out_last == bt.last, bt.tag, "R7 last flag",
                              longint'(out_last), longint'(bt.last));
                    end
                    if (out_last) pkt_open = 1'b0;
                end
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog expired: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "req_ready after reset", longint'(req_ready), 1);
        check(hdr_valid == 1'b0, "R1", "hdr_valid after reset", longint'(hdr_valid), 0);
        check(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
        @(posedge clk); #1;

        run_req('h000, 512,  0, 0, 0, 0, 1, "R2");   // 4 x 128
        run_req('h040, 512,  1, 0, 1, 0, 2, "R4");   // 192, 256, 64
        run_req('h1F8, 1024, 2, 0, 2, 0, 3, "R4");   // 8, 512, 504
        run_req('h010, 296,  3, 0, 3, 0, 4, "R2");   // code 3 -> 128: 112, 128, 56
        run_req('h000, 512,  2, 1, 2, 1, 5, "R3");   // override: 4 x 128
        stall_mode = 1'b1;
        run_req('h008, 4096, 2, 0, 2, 0, 6, "R10");  // 504, 7 x 512, 8
        run_req('h0A8, 8,    1, 0, 1, 0, 7, "R5");   // single beat
        run_req('h000, 512,  2, 0, 0, 1, 8, "R8");   // late change ignored: one 512 packet
        stall_mode = 1'b0;
        run_req('h080, 256,  2, 1, 2, 0, 9, "R8");   // captured override holds: 128, 128
        run_req('h100, 200,  1, 0, 1, 0, 10, "R5");  // 200 bytes inside one 256 window

        for (int w = 0; w < 2000; w++) begin
            if (exp_hdr_q.size() == 0 && exp_beat_q.size() == 0 && req_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        check(exp_hdr_q.size() == 0, "R5", "headers outstanding", exp_hdr_q.size(), 0);
        check(exp_beat_q.size() == 0, "R7", "beats outstanding", exp_beat_q.size(), 0);
        check(req_ready == 1'b1, "R10", "idle after last request", longint'(req_ready), 1);
        finish_run();
    end

endmodule